// File: doc/BRIEF.md
# EEPROM Command Responder

This block answers the block-oriented storage commands that a serial frame processor sends to its accessory channel. The frame processor passes one command at a time as a stream of bytes. The first byte is the opcode, and the expected response length comes with it. The responder checks the command's shape, the device-present input and the configured capacity. It then either returns one 8-byte block, one byte per cycle, or stores one 8-byte block. It ends every command with a one-cycle completion pulse that carries a success flag.

The storage holds up to 256 blocks of 8 bytes. A size select input limits the usable capacity to 512 bytes (64 blocks) or to 2 KiB (256 blocks, the 16-kbit device). A block number times 8 is the byte address. A block that has not been written since reset reads back as all 0xFF. The block keeps one written flag per block for this, so no sweep of the storage is needed after reset.

The control is a seven-state machine:
- IDLE waits for a first byte and goes to GATHER, or straight to JUDGE when that byte is also the last.
- GATHER takes the remaining bytes and goes to JUDGE on the last one.
- JUDGE goes to FETCH for an accepted read, to STORE for an accepted write, and to REPLY when the command fails.
- FETCH loads the addressed block into the output shifter and goes to STREAM.
- STREAM sends 8 bytes and then goes to REPLY.
- STORE writes the block and goes to REPLY.
- REPLY raises the completion pulse and returns to IDLE.

Top module: `eeprom_cmd_responder`

## Requirements
- R1: After reset, in_ready is 1, rsp_valid is 0 and done is 0. Every block reads back as eight 0xFF bytes until it is written.
- R2: A read has opcode 0x04, exactly 2 command bytes (opcode, then block number) and in_rx_len = 8. When accepted, it drives rsp_valid for exactly 8 consecutive cycles. Beat i carries byte address block*8+i. In the cycle after the last beat, done is 1 with done_ok = 1.
- R3: A write has opcode 0x05, exactly 10 command bytes (opcode, block number, then data bytes 0 to 7) and in_rx_len = 0. When accepted, data byte i is stored at byte address block*8+i. The write ends with done and done_ok = 1 and never raises rsp_valid.
- R4: With size_big = 0 the capacity is 512 bytes, and block numbers 64 and above fail. With size_big = 1 the capacity is 2048 bytes, and all block numbers 0 to 255 are accepted.
- R5: When dev_present is 0 in the cycle the command is judged, the command fails.
- R6: A command fails when its opcode is neither 0x04 nor 0x05, or when its command byte count or in_rx_len differs from the values in R2 and R3.
- R7: A failed command raises no rsp_valid, changes no stored byte and ends with done = 1 and done_ok = 0.
- R8: done lasts exactly one cycle. in_ready is 0 from the cycle after the last command byte until the cycle after done. rsp_valid and done are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_big | input | 1 | 1 selects 2 KiB capacity, 0 selects 512 bytes |
| dev_present | input | 1 | Storage device attached |
| in_valid | input | 1 | Command byte valid |
| in_first | input | 1 | Byte is the opcode (first of the command) |
| in_last | input | 1 | Byte is the last of the command |
| in_byte | input | 8 | Command byte |
| in_rx_len | input | LEN_W | Expected response length, sampled with the first byte |
| in_ready | output | 1 | Command bytes are accepted |
| rsp_valid | output | 1 | Response byte valid |
| rsp_byte | output | 8 | Response byte |
| done | output | 1 | Command complete, one-cycle pulse |
| done_ok | output | 1 | Completion result, 1 for success |

## Verification
The bench builds the responder with its default sizes of 512 and 2048 bytes and an 8-bit length field. Random block numbers across 0 to 255 therefore fall on both sides of the small-capacity limit, while the full byte range stays legal at the large size. Because the two capacities share the same storage, a rejected small-mode write to block 64 can be checked later through a large-mode read of that block. Random commands mix correct and wrong lengths, absent devices and foreign opcodes, all checked against a byte-level reference array. Directed cases cover the boundary blocks 63, 64 and 255.

// File: rtl/eeprom_resp_pkg.sv
package eeprom_resp_pkg;

    localparam logic [7:0] OP_READ  = 8'h04;
    localparam logic [7:0] OP_WRITE = 8'h05;
    localparam int         BLOCK_BYTES = 8;
    localparam int         BLOCK_BITS  = BLOCK_BYTES * 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GATHER,
        S_JUDGE,
        S_FETCH,
        S_STREAM,
        S_STORE,
        S_REPLY
    } resp_state_t;

endpackage

// File: rtl/eer_judge.sv
module eer_judge
    import eeprom_resp_pkg::*;
#(
    parameter int LEN_W        = 8,
    parameter int SMALL_BLOCKS = 64,
    parameter int LARGE_BLOCKS = 256
) (
    input  logic [7:0]       opcode,
    input  logic [LEN_W-1:0] tx_count,
    input  logic [LEN_W-1:0] rx_len,
    input  logic [7:0]       blk,
    input  logic             present,
    input  logic             big,
    output logic             accept,
    output logic             is_read
);
    localparam logic [8:0] SMALL_LIM = 9'(SMALL_BLOCKS);
    localparam logic [8:0] LARGE_LIM = 9'(LARGE_BLOCKS);

    logic is_write;
    logic shape_ok;
    logic in_range;

    always_comb begin
        is_read  = (opcode == OP_READ);
        is_write = (opcode == OP_WRITE);
        if (is_read)
            shape_ok = (tx_count == LEN_W'(2)) && (rx_len == LEN_W'(BLOCK_BYTES));
        else if (is_write)
            shape_ok = (tx_count == LEN_W'(2 + BLOCK_BYTES)) && (rx_len == '0);
        else
            shape_ok = 1'b0;
        in_range = big ? ({1'b0, blk} < LARGE_LIM) : ({1'b0, blk} < SMALL_LIM);
        accept   = present && shape_ok && in_range;
    end

endmodule

// File: rtl/eer_block_store.sv
module eer_block_store #(
    parameter int NUM_BLOCKS = 256,
    parameter int WORD_W     = 64,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0]     mem [NUM_BLOCKS];
    logic [NUM_BLOCKS-1:0] written_q;

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            written_q <= '0;
        else if (wr_en)
            written_q[wr_idx] <= 1'b1;
    end

    always_comb begin
        rd_data = written_q[rd_idx] ? mem[rd_idx] : '1;
    end

endmodule

// File: rtl/eer_resp_shifter.sv
module eer_resp_shifter #(
    parameter int NBYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [NBYTES*8-1:0] load_data,
    output logic [7:0]          byte_out
);
    logic [NBYTES*8-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '1;
        else if (load)
            sh_q <= load_data;
        else if (shift)
            sh_q <= {8'hFF, sh_q[NBYTES*8-1:8]};
    end

    assign byte_out = sh_q[7:0];

endmodule

// File: rtl/eeprom_cmd_responder.sv
module eeprom_cmd_responder
    import eeprom_resp_pkg::*;
#(
    parameter int SMALL_BYTES = 512,
    parameter int LARGE_BYTES = 2048,
    parameter int LEN_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             size_big,
    input  logic             dev_present,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             in_last,
    input  logic [7:0]       in_byte,
    input  logic [LEN_W-1:0] in_rx_len,
    output logic             in_ready,
    output logic             rsp_valid,
    output logic [7:0]       rsp_byte,
    output logic             done,
    output logic             done_ok
);
    localparam int SMALL_BLOCKS = SMALL_BYTES / BLOCK_BYTES;
    localparam int LARGE_BLOCKS = LARGE_BYTES / BLOCK_BYTES;
    localparam int IDX_W        = $clog2(LARGE_BLOCKS);
    localparam int BEAT_W       = $clog2(BLOCK_BYTES);

    resp_state_t state_q, state_d;

    logic [7:0]            opc_q;
    logic [LEN_W-1:0]      rxlen_q;
    logic [LEN_W-1:0]      txcnt_q;
    logic [7:0]            blk_q;
    logic [BLOCK_BITS-1:0] wbuf_q;
    logic                  ok_q;
    logic [BEAT_W-1:0]     beat_q;

    logic                  accept;
    logic                  is_read;
    logic [BLOCK_BITS-1:0] rd_block;
    logic [2:0]            wb_sel;
    logic                  take;

    assign take   = in_valid && (state_q == S_GATHER);
    assign wb_sel = 3'(txcnt_q - LEN_W'(2));

    eer_judge #(
        .LEN_W        (LEN_W),
        .SMALL_BLOCKS (SMALL_BLOCKS),
        .LARGE_BLOCKS (LARGE_BLOCKS)
    ) u_judge (
        .opcode   (opc_q),
        .tx_count (txcnt_q),
        .rx_len   (rxlen_q),
        .blk      (blk_q),
        .present  (dev_present),
        .big      (size_big),
        .accept   (accept),
        .is_read  (is_read)
    );

    eer_block_store #(
        .NUM_BLOCKS (LARGE_BLOCKS),
        .WORD_W     (BLOCK_BITS),
        .IDX_W      (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (state_q == S_STORE),
        .wr_idx  (blk_q[IDX_W-1:0]),
        .wr_data (wbuf_q),
        .rd_idx  (blk_q[IDX_W-1:0]),
        .rd_data (rd_block)
    );

    eer_resp_shifter #(
        .NBYTES (BLOCK_BYTES)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == S_FETCH),
        .shift     (state_q == S_STREAM),
        .load_data (rd_block),
        .byte_out  (rsp_byte)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (in_valid && in_first) state_d = in_last ? S_JUDGE : S_GATHER;
            S_GATHER: if (in_valid && in_last) state_d = S_JUDGE;
            S_JUDGE:  state_d = !accept ? S_REPLY : (is_read ? S_FETCH : S_STORE);
            S_FETCH:  state_d = S_STREAM;
            S_STREAM: if (beat_q == BEAT_W'(BLOCK_BYTES - 1)) state_d = S_REPLY;
            S_STORE:  state_d = S_REPLY;
            S_REPLY:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // command capture and sequencing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_q   <= '0;
            rxlen_q <= '0;
            txcnt_q <= '0;
            blk_q   <= '0;
            wbuf_q  <= '0;
            ok_q    <= 1'b0;
            beat_q  <= '0;
        end else begin
            if (state_q == S_IDLE && in_valid && in_first) begin
                opc_q   <= in_byte;
                rxlen_q <= in_rx_len;
                txcnt_q <= LEN_W'(1);
            end
            if (take) begin
                if (txcnt_q == LEN_W'(1))
                    blk_q <= in_byte;
                if (txcnt_q >= LEN_W'(2) && txcnt_q <= LEN_W'(1 + BLOCK_BYTES))
                    wbuf_q[{wb_sel, 3'b000} +: 8] <= in_byte;
                if (txcnt_q != '1)
                    txcnt_q <= txcnt_q + LEN_W'(1);
            end
            if (state_q == S_JUDGE)
                ok_q <= accept;
            if (state_q == S_FETCH)
                beat_q <= '0;
            else if (state_q == S_STREAM)
                beat_q <= beat_q + BEAT_W'(1);
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        rsp_valid = 1'b0;
        done      = 1'b0;
        done_ok   = 1'b0;
        unique case (state_q)
            S_IDLE, S_GATHER: in_ready = 1'b1;
            S_STREAM:         rsp_valid = 1'b1;
            S_REPLY: begin
                done    = 1'b1;
                done_ok = ok_q;
            end
            S_JUDGE, S_FETCH, S_STORE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/eeprom_cmd_responder_chk.sv
module eeprom_cmd_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic rsp_valid,
    input logic done,
    input logic done_ok
);
    logic [3:0] beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            beats_q <= '0;
        else if (done)
            beats_q <= '0;
        else if (rsp_valid && beats_q != 4'hF)
            beats_q <= beats_q + 4'd1;
    end

    p_read_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && beats_q != 4'd0) |-> (beats_q == 4'd8 && done_ok));

    p_beats_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        beats_q <= 4'd8);

    p_stream_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsp_valid) |-> done);

    p_fail_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> beats_q == 4'd0);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || done) |-> !in_ready);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && done));

endmodule

bind eeprom_cmd_responder eeprom_cmd_responder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .rsp_valid (rsp_valid),
    .done      (done),
    .done_ok   (done_ok)
);

// File: tb/eeprom_cmd_responder_tb_top.sv
module eeprom_cmd_responder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       size_big = 1'b1;
    logic       dev_present = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] in_rx_len = 8'h00;
    logic       in_ready, rsp_valid, done, done_ok;
    logic [7:0] rsp_byte;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [7:0] ref_mem [2048];

    always #5 clk = ~clk;

    eeprom_cmd_responder dut_i (
        .clk(clk), .rst_n(rst_n), .size_big(size_big), .dev_present(dev_present),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_byte(in_byte), .in_rx_len(in_rx_len), .in_ready(in_ready),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .done(done), .done_ok(done_ok)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_accept(input logic [7:0] opc, input int blk, input int tx,
                                      input int rx, input bit big, input bit pres);
        bit shape;
        shape = (opc == 8'h04 && tx == 2 && rx == 8) ||
                (opc == 8'h05 && tx == 10 && rx == 0);
        return pres && shape && (big ? blk < 256 : blk < 64);
    endfunction

    function automatic logic [63:0] ref_block(input int blk);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = ref_mem[blk*8 + i];
        return v;
    endfunction

    task automatic run_cmd(input string tag, input logic [7:0] opc, input int blk,
                           input logic [63:0] data, input int tx, input int rx,
                           input bit big, input bit pres);
        bit          exp_ok, seen, got_ok;
        int          beats;
        logic [63:0] got, expd;
        exp_ok = exp_accept(opc, blk, tx, rx, big, pres);
        expd   = ref_block(blk);
        size_big = big;
        dev_present = pres;
        for (int k = 0; k < tx; k++) begin
            @(negedge clk);
            if (!in_ready) begin
                errors++; checks++;
                $display("FAIL %s R8 in_ready actual=0 expected=1", tag);
            end
            in_valid  = 1'b1;
            in_first  = (k == 0);
            in_last   = (k == tx - 1);
            in_rx_len = 8'(rx);
            in_byte   = (k == 0) ? opc : (k == 1) ? 8'(blk) :
                        (k < 10) ? data[8*(k-2) +: 8] : 8'hA5;
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        seen = 0; got_ok = 0; beats = 0; got = '1;
        for (int w = 0; w < 40; w++) begin
            if (rsp_valid) begin
                if (beats < 8) got[8*beats +: 8] = rsp_byte;
                beats++;
            end
            if (done) begin
                seen = 1; got_ok = done_ok;
                break;
            end
            @(negedge clk);
        end
        check({tag, " done seen (R8)"}, 64'(seen), 64'd1);
        check({tag, " ok flag"}, 64'(got_ok), 64'(exp_ok));
        check({tag, " beats (R2/R7)"}, 64'(beats),
              (exp_ok && opc == 8'h04) ? 64'd8 : 64'd0);
        if (exp_ok && opc == 8'h04)
            check({tag, " read data R2"}, got, expd);
        if (exp_ok && opc == 8'h05)
            for (int i = 0; i < 8; i++) ref_mem[blk*8 + i] = data[8*i +: 8];
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready after reset", 64'(in_ready), 64'd1);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R1 done after reset", 64'(done), 64'd0);

        run_cmd("R1 fresh read", 8'h04, 5, 64'h0, 2, 8, 1, 1);
        run_cmd("R3 write blk5", 8'h05, 5, 64'h8877665544332211, 10, 0, 1, 1);
        run_cmd("R2 read blk5", 8'h04, 5, 64'h0, 2, 8, 1, 1);
        run_cmd("R4 small write 63", 8'h05, 63, 64'h0123456789ABCDEF, 10, 0, 0, 1);
        run_cmd("R4 small read 63", 8'h04, 63, 64'h0, 2, 8, 0, 1);
        run_cmd("R4 small read 64", 8'h04, 64, 64'h0, 2, 8, 0, 1);
        run_cmd("R7 small write 64", 8'h05, 64, 64'hDEADBEEFCAFEF00D, 10, 0, 0, 1);
        run_cmd("R7 big read 64", 8'h04, 64, 64'h0, 2, 8, 1, 1);
        run_cmd("R4 big write 255", 8'h05, 255, 64'h1122334455667788, 10, 0, 1, 1);
        run_cmd("R4 big read 255", 8'h04, 255, 64'h0, 2, 8, 1, 1);
        run_cmd("R5 absent read", 8'h04, 5, 64'h0, 2, 8, 1, 0);
        run_cmd("R5 absent write", 8'h05, 5, 64'hFFFF0000FFFF0000, 10, 0, 1, 0);
        run_cmd("R6 tx1 read", 8'h04, 0, 64'h0, 1, 8, 1, 1);
        run_cmd("R6 rx7 read", 8'h04, 5, 64'h0, 2, 7, 1, 1);
        run_cmd("R6 tx9 write", 8'h05, 5, 64'h0, 9, 0, 1, 1);
        run_cmd("R6 rx8 write", 8'h05, 5, 64'h0, 10, 8, 1, 1);
        run_cmd("R6 opcode 06", 8'h06, 5, 64'h0, 2, 8, 1, 1);
        run_cmd("R7 verify blk5", 8'h04, 5, 64'h0, 2, 8, 1, 1);

        for (int n = 0; n < 400; n++) begin
            logic [7:0]  opc;
            logic [63:0] d;
            int          blk, tx, rx, sel;
            bit          big, pres;
            sel  = int'($urandom_range(0, 19));
            opc  = (sel < 9) ? 8'h04 : (sel < 18) ? 8'h05 : 8'($urandom_range(0, 255));
            blk  = int'($urandom_range(0, 255));
            big  = 1'($urandom_range(0, 1));
            pres = ($urandom_range(0, 9) != 0);
            d    = {$urandom, $urandom};
            tx   = (opc == 8'h05) ? 10 : 2;
            rx   = (opc == 8'h05) ? 0 : 8;
            if ($urandom_range(0, 9) == 0) tx = int'($urandom_range(1, 12));
            if ($urandom_range(0, 9) == 0) rx = int'($urandom_range(0, 9));
            run_cmd("R2/R3/R4/R6 random", opc, blk, d, tx, rx, big, pres);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule